// File: doc/BRIEF.md
# Fixed Off-Time Chopper Controller

This block regulates the current in one H-bridge winding by chopping its drive. It handles one winding of a two-phase motor driver. A digital current-trip comparator ends each drive phase. After a trip the bridge decays the winding current for a fixed number of clock cycles. The decay is slow, fast or mixed. When the off-time ends, the same diagonal is driven again. Leading-edge blanking masks the trip comparator at the start of each drive phase. A second comparator tells mixed decay when to change from fast to slow recirculation.

The block can also turn the recirculating low or high switches on, which is called synchronous rectification. It turns them off again when a zero-current detector fires, so that the winding current cannot reverse. Each leg of the bridge has a dead-time guard that keeps its two switches from conducting together. The blanking time, the off-time and the dead time are clock-cycle counts given at the ports.

Top module: `chop_ctrl`

## Requirements
- R1: While driving, gates {ah,al,bh,bl} are 1001 when the polarity is 1 and 0110 when it is 0. The polarity is sampled each time a drive phase starts.
- R2: During the first `blank_time_i` cycles of each drive phase, the trip input is ignored. With the trip held high, each drive-side high-switch pulse lasts `blank_time_i`+1 cycles.
- R3: An accepted trip starts a decay phase that lasts `off_time_i` cycles, after which drive resumes. With the trip held high and `off_time_i` > `dead_time_i`, the drive-side high switch stays off for `off_time_i` cycles.
- R4: Decay mode 00 (slow) with rectification off turns off only the drive-side high switch (polarity 1 gives 0001).
- R5: Decay mode 01 (fast) with rectification off turns all four gates off.
- R6: Decay mode 1x (mixed) starts each off-time in fast decay. It changes to slow decay when `decay_cmp_i` is high, and stays in slow decay for the rest of that off-time, even if `decay_cmp_i` falls again.
- R7: In mixed mode, if `decay_cmp_i` stays low, fast decay lasts for the whole off-time.
- R8: Rectification is on when `rect_n_i` is 0. Slow decay then also turns on the drive-side low switch (polarity 1 gives 0101). Fast decay turns on the drive-side low switch and the sink-side high switch (0110).
- R9: With rectification on, `zero_cur_i` high during decay turns the rectifying switches off for the rest of that off-time. The next decay phase rectifies again.
- R10: The two switches of one leg are never on together. A switch that replaces the other switch of its leg turns on after exactly `dead_time_i`+1 cycles with both off.
- R11: `disable_i` turns all four gates off on the next clock edge and keeps them off. On release, the controller restarts from idle into a drive phase.
- R12: During reset, all four gates are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| disable_i | input | 1 | Forces gates off, returns to idle |
| polarity_i | input | 1 | Current direction: 1 drives A high / B low |
| decay_mode_i | input | 2 | 00 slow, 01 fast, 1x mixed |
| rect_n_i | input | 1 | Active-low synchronous rectification enable |
| trip_cmp_i | input | 1 | Current-trip comparator output |
| decay_cmp_i | input | 1 | Sense level below the mixed-decay threshold |
| zero_cur_i | input | 1 | Zero-current detect |
| blank_time_i | input | CNT_W | Blanking cycles |
| off_time_i | input | CNT_W | Off-time cycles |
| dead_time_i | input | CNT_W | Dead-time count |
| gate_ah_o | output | 1 | Leg A high-side gate |
| gate_al_o | output | 1 | Leg A low-side gate |
| gate_bh_o | output | 1 | Leg B high-side gate |
| gate_bl_o | output | 1 | Leg B low-side gate |

## Verification
The phase-timing assertions assume that the blanking, off-time and dead-time counts do not change while the controller is running. The bench sets them once, before reset is released. The mixed-decay latch assertion assumes the decay mode is sampled only when a trip is accepted. The stimulus therefore changes the mode only outside an off-time, and changes the polarity only while the bridge is disabled. Trip pulses are applied only after the blanking window has long expired, except in the held-trip run, which measures the blanking and off-time windows directly at the gates.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRIVE = 2'd1,
    ST_DECAY = 2'd2
  } chop_state_e;

  localparam logic [1:0] DEC_SLOW = 2'b00;
  localparam logic [1:0] DEC_FAST = 2'b01;
  localparam int         LEGS     = 2;
endpackage

// File: rtl/chop_fsm.sv
module chop_fsm
  import chop_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             disable_i,
  input  logic             polarity_i,
  input  logic [1:0]       decay_mode_i,
  input  logic             rect_n_i,
  input  logic             trip_cmp_i,
  input  logic             decay_cmp_i,
  input  logic             zero_cur_i,
  input  logic [CNT_W-1:0] blank_time_i,
  input  logic [CNT_W-1:0] off_time_i,
  output logic [LEGS-1:0]  hi_req_o,
  output logic [LEGS-1:0]  lo_req_o
);
  chop_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pol_q, mixed_q, slow_q, zc_q;

  logic [CNT_W:0] cnt_inc;
  logic           cnt_sat, blank_done, off_done, rect_en, rect_on;
  logic           drv_idx, snk_idx;

  assign cnt_inc    = {1'b0, cnt_q} + 1'b1;
  assign cnt_sat    = &cnt_q;
  assign blank_done = cnt_q >= blank_time_i;
  assign off_done   = cnt_inc >= {1'b0, off_time_i};
  assign rect_en    = !rect_n_i;
  assign rect_on    = rect_en && !zc_q;
  // leg 0 = A, leg 1 = B; polarity 1 drives from A
  assign drv_idx    = !pol_q;
  assign snk_idx    = pol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pol_q   <= 1'b0;
      mixed_q <= 1'b0;
      slow_q  <= 1'b0;
      zc_q    <= 1'b0;
    end else if (disable_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      mixed_q <= 1'b0;
      slow_q  <= 1'b0;
      zc_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_q <= ST_DRIVE;
          cnt_q   <= '0;
          pol_q   <= polarity_i;
        end
        ST_DRIVE: begin
          if (trip_cmp_i && blank_done) begin
            state_q <= ST_DECAY;
            cnt_q   <= '0;
            mixed_q <= decay_mode_i[1];
            slow_q  <= (decay_mode_i == DEC_SLOW);
            zc_q    <= 1'b0;
          end else if (!cnt_sat) begin
            cnt_q <= cnt_inc[CNT_W-1:0];
          end
        end
        ST_DECAY: begin
          if (off_done) begin
            state_q <= ST_DRIVE;
            cnt_q   <= '0;
            pol_q   <= polarity_i;
          end else begin
            cnt_q <= cnt_inc[CNT_W-1:0];
          end
          if (mixed_q && decay_cmp_i) slow_q <= 1'b1;
          if (rect_en && zero_cur_i)  zc_q   <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    hi_req_o = '0;
    lo_req_o = '0;
    if (state_q == ST_DRIVE) begin
      hi_req_o[drv_idx] = 1'b1;
      lo_req_o[snk_idx] = 1'b1;
    end else if (state_q == ST_DECAY) begin
      lo_req_o[drv_idx] = rect_on;
      if (slow_q) lo_req_o[snk_idx] = 1'b1;
      else        hi_req_o[snk_idx] = rect_on;
    end
  end

  assert_blank_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DRIVE && !blank_done && !disable_i) |=> state_q == ST_DRIVE);

  assert_off_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DECAY && !off_done && !disable_i) |=> state_q == ST_DECAY);

  assert_mixed_latch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DECAY && slow_q && !off_done && !disable_i) |=> slow_q);

  assert_idle_on_disable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disable_i |=> state_q == ST_IDLE);
endmodule

// File: rtl/chop_leg.sv
module chop_leg #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             disable_i,
  input  logic [CNT_W-1:0] dead_time_i,
  input  logic             hi_req_i,
  input  logic             lo_req_i,
  output logic             hi_o,
  output logic             lo_o
);
  logic [CNT_W-1:0] gap_q;
  logic             drop;

  assign drop = (hi_o && !hi_req_i) || (lo_o && !lo_req_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_o  <= 1'b0;
      lo_o  <= 1'b0;
      gap_q <= '0;
    end else if (disable_i) begin
      hi_o  <= 1'b0;
      lo_o  <= 1'b0;
      gap_q <= '0;
    end else if (drop) begin
      hi_o  <= hi_o && hi_req_i;
      lo_o  <= lo_o && lo_req_i;
      gap_q <= '0;
    end else if (!hi_o && !lo_o) begin
      if ((hi_req_i || lo_req_i) && gap_q >= dead_time_i) begin
        hi_o <= hi_req_i;
        lo_o <= lo_req_i && !hi_req_i;
      end else if (!(&gap_q)) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  assert_leg_no_overlap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_o && lo_o));

  assert_hi_after_gap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hi_o) |-> !$past(lo_o));

  assert_lo_after_gap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lo_o) |-> !$past(hi_o));

  assert_leg_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disable_i |=> (!hi_o && !lo_o));
endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
  import chop_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             disable_i,
  input  logic             polarity_i,
  input  logic [1:0]       decay_mode_i,
  input  logic             rect_n_i,
  input  logic             trip_cmp_i,
  input  logic             decay_cmp_i,
  input  logic             zero_cur_i,
  input  logic [CNT_W-1:0] blank_time_i,
  input  logic [CNT_W-1:0] off_time_i,
  input  logic [CNT_W-1:0] dead_time_i,
  output logic             gate_ah_o,
  output logic             gate_al_o,
  output logic             gate_bh_o,
  output logic             gate_bl_o
);
  logic [LEGS-1:0] hi_req, lo_req, hi_g, lo_g;

  chop_fsm #(.CNT_W(CNT_W)) fsm_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .disable_i   (disable_i),
    .polarity_i  (polarity_i),
    .decay_mode_i(decay_mode_i),
    .rect_n_i    (rect_n_i),
    .trip_cmp_i  (trip_cmp_i),
    .decay_cmp_i (decay_cmp_i),
    .zero_cur_i  (zero_cur_i),
    .blank_time_i(blank_time_i),
    .off_time_i  (off_time_i),
    .hi_req_o    (hi_req),
    .lo_req_o    (lo_req)
  );

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    chop_leg #(.CNT_W(CNT_W)) leg_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .disable_i  (disable_i),
      .dead_time_i(dead_time_i),
      .hi_req_i   (hi_req[g]),
      .lo_req_i   (lo_req[g]),
      .hi_o       (hi_g[g]),
      .lo_o       (lo_g[g])
    );
  end

  assign gate_ah_o = hi_g[0];
  assign gate_al_o = lo_g[0];
  assign gate_bh_o = hi_g[1];
  assign gate_bl_o = lo_g[1];

  assert_no_supply_short_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_ah_o && gate_al_o) && !(gate_bh_o && gate_bl_o));

  assert_gates_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disable_i |=> !(gate_ah_o || gate_al_o || gate_bh_o || gate_bl_o));
endmodule

// File: tb/chop_ctrl_tb_top.sv
`timescale 1ns/1ps
module chop_ctrl_tb_top;
  localparam int CNT_W = 8;
  localparam int DEAD  = 2;
  localparam int BLANK = 4;
  localparam int OFF   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dis = 1'b0, pol = 1'b1, rect_n = 1'b1;
  logic trip = 1'b0, dcmp = 1'b0, zero = 1'b0;
  logic [1:0] mode = 2'b00;
  logic ah, al, bh, bl;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct {
    string      tag;
    logic [3:0] exp;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  chop_ctrl #(.CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .disable_i(dis), .polarity_i(pol),
    .decay_mode_i(mode), .rect_n_i(rect_n), .trip_cmp_i(trip),
    .decay_cmp_i(dcmp), .zero_cur_i(zero),
    .blank_time_i(CNT_W'(BLANK)), .off_time_i(CNT_W'(OFF)),
    .dead_time_i(CNT_W'(DEAD)),
    .gate_ah_o(ah), .gate_al_o(al), .gate_bh_o(bh), .gate_bl_o(bl)
  );

  // monitor: compare queued expectations against the gates
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if ({ah, al, bh, bl} !== it.exp) begin
        failures++;
        $display("FAIL %s: got %b exp %b", it.tag, {ah, al, bh, bl}, it.exp);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic expect_gates(input string tag, input logic [3:0] exp);
    sb_q.push_back('{tag: tag, exp: exp});
  endtask

  task automatic check_val(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got %0d exp %0d", tag, got, exp);
    end
  endtask

  task automatic trip_pulse();
    trip = 1'b1;
    step(1);
    trip = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int gap, hi_len, lo_len, guard;
    #3;
    expect_gates("R12 reset state", 4'b0000);
    step(3);
    rst_n = 1'b1;
    step(8);
    expect_gates("R1 drive pol=1", 4'b1001);

    // slow decay without rectification
    trip_pulse();
    step(7);
    expect_gates("R4 slow decay", 4'b0001);
    step(20);
    expect_gates("R3 drive resumes", 4'b1001);

    // slow decay with rectification: dead gap then R8 pattern
    rect_n = 1'b0;
    trip_pulse();
    gap = 0;
    guard = 0;
    while (!al && guard < 40) begin
      if (!ah && !al) gap++;
      step(1);
      guard++;
    end
    check_val("R10 dead gap", gap, DEAD + 1);
    step(2);
    expect_gates("R8 slow rectify", 4'b0101);
    zero = 1'b1;
    step(2);
    zero = 1'b0;
    step(1);
    expect_gates("R9 zero cut slow", 4'b0001);
    step(20);

    // fast decay with rectification
    mode = 2'b01;
    trip_pulse();
    step(7);
    expect_gates("R8 fast rectify", 4'b0110);
    zero = 1'b1;
    step(2);
    zero = 1'b0;
    step(1);
    expect_gates("R9 zero cut fast", 4'b0000);
    step(20);

    // zero latch cleared on next decay
    mode = 2'b00;
    trip_pulse();
    step(7);
    expect_gates("R9 rectify rearmed", 4'b0101);
    step(20);

    // fast decay without rectification
    rect_n = 1'b1;
    mode = 2'b01;
    trip_pulse();
    step(7);
    expect_gates("R5 fast decay", 4'b0000);
    step(20);

    // mixed, threshold never reached
    mode = 2'b10;
    trip_pulse();
    step(13);
    expect_gates("R7 mixed stays fast", 4'b0000);
    step(20);

    // mixed, threshold reached partway
    trip_pulse();
    step(5);
    expect_gates("R6 mixed starts fast", 4'b0000);
    dcmp = 1'b1;
    step(4);
    expect_gates("R6 mixed to slow", 4'b0001);
    dcmp = 1'b0;
    step(3);
    expect_gates("R6 mixed slow latched", 4'b0001);
    step(20);

    // held trip: measure blanking and off-time at the gates
    mode = 2'b01;
    trip = 1'b1;
    guard = 0;
    while (ah && guard < 60) begin step(1); guard++; end
    while (!ah && guard < 60) begin step(1); guard++; end
    hi_len = 0;
    while (ah && guard < 120) begin hi_len++; step(1); guard++; end
    lo_len = 0;
    while (!ah && guard < 120) begin lo_len++; step(1); guard++; end
    check_val("R2 blanked drive pulse", hi_len, BLANK + 1);
    check_val("R3 off-time length", lo_len, OFF);
    trip = 1'b0;
    step(10);

    // disable and polarity
    dis = 1'b1;
    step(1);
    expect_gates("R11 disable off", 4'b0000);
    trip_pulse();
    step(4);
    expect_gates("R11 disable holds", 4'b0000);
    pol = 1'b0;
    dis = 1'b0;
    step(8);
    expect_gates("R1 drive pol=0", 4'b0110);
    trip_pulse();
    step(7);
    expect_gates("R5 fast decay pol=0", 4'b0000);
    step(20);
    expect_gates("R3 resume pol=0", 4'b0110);

    step(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule